// File: doc/BRIEF.md
# Contactless Field Event Indicator

This block drives one event pin that wakes or informs a sleeping host controller about activity on a contactless interface. A two-bit mode setting picks which event the pin reports. The four choices are plain reader-field presence, the start of protocol traffic with a reader, selection of the tag by a reader, and a handshake for a shared pass-through buffer. The same event is also given as an active-high status bit, so the host can read it as well.

The field-presence level and the protocol-start indication come from another clock domain. Each goes through a two-flop synchronizer before the logic uses it. Tag selection and the buffer signals are already synchronous to `clk`.

The mode setting is only taken while no field is present. A host write made during a session therefore cannot change what the pin means partway through that session. The pin is active low by default, and a parameter makes it active high.

Top module: `fe_event_sel`

## Requirements
- R1: While `rst_n` is low and after reset, `status_o` is 0, `evt_pin_o` is 1 (default polarity) and the active mode is field presence (code 00).
- R2: In mode 00, `status_o` follows `field_async_i`. A change of `field_async_i` that is set up before a rising edge appears on `status_o` after the third rising edge, and not after the second.
- R3: In mode 01, a rising edge of the synchronized `start_async_i` while the synchronized field is present sets `status_o`. `status_o` then stays at 1 until the field is lost, and returns to 0 within five cycles after `field_async_i` falls.
- R4: In mode 10, a one-cycle `select_i` pulse while the synchronized field is present sets `status_o` two edges later. It stays set until the field is lost.
- R5: In mode 11, a rising edge of `buf_ready_i` sets `status_o` (buffer ready for the host).
- R6: In mode 11, each cycle with `buf_done_i` high inverts the indicator. When a `buf_done_i` pulse and a rising edge of `buf_ready_i` fall in the same cycle, the inversion wins.
- R7: `mode_cfg_i` is captured only while the synchronized field is absent. A mode change requested during a field session has no effect on `status_o` until the field is gone.
- R8: `evt_pin_o` is the inverse of `status_o` when `ACTIVE_HIGH` is 0, and equal to it when `ACTIVE_HIGH` is 1.
- R9: In modes 01 and 10, start or select events that occur while the field is absent leave `status_o` at 0.
- R10: Leaving mode 11 clears the pass-through indicator. A later return to mode 11 starts with `status_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| field_async_i | input | 1 | Reader field present, asynchronous level |
| start_async_i | input | 1 | Protocol traffic started, asynchronous level |
| select_i | input | 1 | One-cycle pulse: tag selected by a reader |
| buf_ready_i | input | 1 | Shared buffer ready for the host, level |
| buf_done_i | input | 1 | One-cycle pulse: a buffer exchange completed |
| mode_cfg_i | input | 2 | Event source: 00 field, 01 start, 10 selected, 11 pass-through |
| evt_pin_o | output | 1 | Event pin, polarity set by `ACTIVE_HIGH` |
| status_o | output | 1 | Active-high copy of the event for the host |

## Verification
In pass-through mode, a completed-exchange pulse and a ready rising edge can arrive in the same cycle. The bench first sets the indicator and drops ready, then raises ready and pulses done together. It expects the indicator to invert to 0 instead of being set.

A second collision is a mode write made while a field is active. The bench makes that write and expects the old mode to stay in effect until the field is gone. A behavioural model compares both polarity variants against the design on every clock.

// File: rtl/fe_event_pkg.sv
// Shared types for the field-event selector.
// Assumes: the mode encoding is fixed by the host register layout.
package fe_event_pkg;
    typedef enum logic [1:0] {
        FE_FIELD = 2'b00,
        FE_COMM  = 2'b01,
        FE_SEL   = 2'b10,
        FE_PASS  = 2'b11
    } fe_mode_e;
endpackage

// File: rtl/fe_sync.sv
// Multi-flop synchronizer for asynchronous level inputs.
// Assumes: inputs are levels that stay stable for longer than STAGES cycles.
module fe_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // First flop captures the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= d_i;
            end
        end else begin : g_next
            // Later flops give metastability time to settle.
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/fe_mode_hold.sv
// Holds the active event mode.
// Assumes: a new mode is accepted only while the field is absent, so that
// the output never changes meaning during a reader session.
module fe_mode_hold
    import fe_event_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       field_s,
    input  logic [1:0] mode_cfg_i,
    output fe_mode_e   mode_q
);
    // Load the requested mode only between sessions.
    always_ff @(posedge clk) begin
        if (!rst_n)        mode_q <= FE_FIELD;
        else if (!field_s) mode_q <= fe_mode_e'(mode_cfg_i);
    end
endmodule

// File: rtl/fe_event_core.sv
// Computes the selected event level and registers it.
// Assumes: field_s and start_s are already synchronized; select and buffer
// signals are synchronous to clk.
module fe_event_core
    import fe_event_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  fe_mode_e mode_q,
    input  logic     field_s,
    input  logic     start_s,
    input  logic     select_i,
    input  logic     buf_ready_i,
    input  logic     buf_done_i,
    output logic     sticky_q,
    output logic     pt_q,
    output logic     ev_q
);
    logic start_d;
    logic rdy_d;
    logic start_evt;
    logic rdy_rise;
    logic sticky_set;
    logic ev_c;

    assign start_evt  = start_s & ~start_d;
    assign rdy_rise   = buf_ready_i & ~rdy_d;
    assign sticky_set = ((mode_q == FE_COMM) & start_evt) |
                        ((mode_q == FE_SEL)  & select_i);

    // Delay copies used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_d <= 1'b0;
            rdy_d   <= 1'b0;
        end else begin
            start_d <= start_s;
            rdy_d   <= buf_ready_i;
        end
    end

    // Session flag for the start and selected modes, cleared on field loss.
    always_ff @(posedge clk) begin
        if (!rst_n)          sticky_q <= 1'b0;
        else if (!field_s)   sticky_q <= 1'b0;
        else if (sticky_set) sticky_q <= 1'b1;
    end

    // Pass-through handshake: done inverts, ready rising sets, done wins.
    always_ff @(posedge clk) begin
        if (!rst_n)                pt_q <= 1'b0;
        else if (mode_q != FE_PASS) pt_q <= 1'b0;
        else if (buf_done_i)       pt_q <= ~pt_q;
        else if (rdy_rise)         pt_q <= 1'b1;
    end

    // Pick the event source for the active mode.
    always_comb begin
        unique case (mode_q)
            FE_FIELD: ev_c = field_s;
            FE_PASS:  ev_c = pt_q;
            default:  ev_c = sticky_q;
        endcase
    end

    // Register the event so the pin is driven straight from a flop.
    always_ff @(posedge clk) begin
        if (!rst_n) ev_q <= 1'b0;
        else        ev_q <= ev_c;
    end
endmodule

// File: rtl/fe_event_sel.sv
// Top of the field-event selector: synchronizes the cross-domain inputs,
// holds the mode and drives the event pin and its status copy.
// Assumes: field and start inputs are asynchronous levels; select and
// buffer inputs come from the clk domain.
module fe_event_sel
    import fe_event_pkg::*;
#(
    parameter bit ACTIVE_HIGH = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       field_async_i,
    input  logic       start_async_i,
    input  logic       select_i,
    input  logic       buf_ready_i,
    input  logic       buf_done_i,
    input  logic [1:0] mode_cfg_i,
    output logic       evt_pin_o,
    output logic       status_o
);
    localparam int SYNC_W = 2;

    logic [SYNC_W-1:0] sync_q;
    logic              field_s;
    logic              start_s;
    fe_mode_e          mode_q;
    logic              sticky_q;
    logic              pt_q;
    logic              ev_q;

    fe_sync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({start_async_i, field_async_i}),
        .q_o   (sync_q)
    );

    assign field_s = sync_q[0];
    assign start_s = sync_q[1];

    fe_mode_hold u_mode (
        .clk        (clk),
        .rst_n      (rst_n),
        .field_s    (field_s),
        .mode_cfg_i (mode_cfg_i),
        .mode_q     (mode_q)
    );

    fe_event_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_q      (mode_q),
        .field_s     (field_s),
        .start_s     (start_s),
        .select_i    (select_i),
        .buf_ready_i (buf_ready_i),
        .buf_done_i  (buf_done_i),
        .sticky_q    (sticky_q),
        .pt_q        (pt_q),
        .ev_q        (ev_q)
    );

    assign status_o = ev_q;

    if (ACTIVE_HIGH) begin : g_pin_high
        assign evt_pin_o = ev_q;
    end else begin : g_pin_low
        assign evt_pin_o = ~ev_q;
    end
endmodule

// File: rtl/fe_event_sel_chk.sv
// Assertion checker for fe_event_sel, attached with bind below.
// Assumes: internal nets are named as in fe_event_sel.
module fe_event_sel_chk
    import fe_event_pkg::*;
#(
    parameter bit ACTIVE_HIGH = 1'b0
) (
    input logic     clk,
    input logic     rst_n,
    input logic     field_s,
    input fe_mode_e mode_q,
    input logic     sticky_q,
    input logic     pt_q,
    input logic     buf_done_i,
    input logic     status_o,
    input logic     evt_pin_o
);
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        field_s |=> $stable(mode_q)); // R7

    AST_FIELD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == FE_FIELD) |=> (status_o == $past(field_s))); // R2

    AST_SESSION_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (field_s && sticky_q && (mode_q == FE_COMM || mode_q == FE_SEL)) |=> sticky_q); // R3

    AST_PASS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_q == FE_PASS) && buf_done_i) |=> (pt_q != $past(pt_q))); // R6

    AST_PIN_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_pin_o == (ACTIVE_HIGH ? status_o : !status_o))); // R8
endmodule

bind fe_event_sel fe_event_sel_chk #(.ACTIVE_HIGH(ACTIVE_HIGH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .field_s    (field_s),
    .mode_q     (mode_q),
    .sticky_q   (sticky_q),
    .pt_q       (pt_q),
    .buf_done_i (buf_done_i),
    .status_o   (status_o),
    .evt_pin_o  (evt_pin_o)
);

// File: tb/fe_event_sel_bench.sv
module fe_event_sel_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic field_in = 1'b0, start_in = 1'b0, sel = 1'b0, rdy = 1'b0, done = 1'b0;
    logic [1:0] mode_cfg = 2'b00;
    logic pin0, stat0, pin1, stat1;
    int checks = 0, errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    fe_event_sel u_fe_event_sel (
        .clk(clk), .rst_n(rst_n), .field_async_i(field_in), .start_async_i(start_in),
        .select_i(sel), .buf_ready_i(rdy), .buf_done_i(done), .mode_cfg_i(mode_cfg),
        .evt_pin_o(pin0), .status_o(stat0));

    fe_event_sel #(.ACTIVE_HIGH(1'b1)) u_fe_event_sel_hi (
        .clk(clk), .rst_n(rst_n), .field_async_i(field_in), .start_async_i(start_in),
        .select_i(sel), .buf_ready_i(rdy), .buf_done_i(done), .mode_cfg_i(mode_cfg),
        .evt_pin_o(pin1), .status_o(stat1));

    // Behavioural reference: delay lines as queues, state as integers.
    int fq[$], sq[$];
    int m_mode, m_sess, m_pt, m_rdy_prev, m_start_prev, m_ev;
    bit m_valid = 1'b0;

    always @(posedge clk) begin : model
        int fs, ss, nev, nsess, npt;
        if (!rst_n) begin
            fq = '{0, 0}; sq = '{0, 0};
            m_mode = 0; m_sess = 0; m_pt = 0; m_rdy_prev = 0; m_start_prev = 0; m_ev = 0;
        end else begin
            fs = fq[0]; ss = sq[0];
            nev = (m_mode == 0) ? fs : (m_mode == 3) ? m_pt : m_sess;
            if (fs == 0) nsess = 0;
            else if ((m_mode == 1 && ss == 1 && m_start_prev == 0) || (m_mode == 2 && sel)) nsess = 1;
            else nsess = m_sess;
            if (m_mode != 3) npt = 0;
            else if (done) npt = 1 - m_pt;
            else if (rdy && m_rdy_prev == 0) npt = 1;
            else npt = m_pt;
            if (fs == 0) m_mode = int'(mode_cfg);
            m_start_prev = ss; m_rdy_prev = int'(rdy);
            m_ev = nev; m_sess = nsess; m_pt = npt;
            void'(fq.pop_front()); fq.push_back(int'(field_in));
            void'(sq.pop_front()); sq.push_back(int'(start_in));
        end
        m_valid = 1'b1;
    end

    task automatic chk(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic string mode_tag(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2: return "R4";
            default: return "R6";
        endcase
    endfunction

    // Every-cycle comparison against the model, away from the clock edge.
    always @(negedge clk) begin
        if (m_valid && !finished) begin
            chk(int'(stat0), m_ev, mode_tag(m_mode));
            chk(int'(pin0), 1 - m_ev, "R8 low pin");
            chk(int'(pin1), m_ev, "R8 high pin");
            chk(int'(stat1), m_ev, "R8 high status");
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        step(4);
        chk(int'(stat0), 0, "R1 status in reset");
        chk(int'(pin0), 1, "R1 pin in reset");
        rst_n = 1'b1;
        step(2);
        chk(int'(stat0), 0, "R1 status after reset");
        // R2 field presence latency
        field_in = 1'b1; step(2);
        chk(int'(stat0), 0, "R2 not before third edge");
        step(1);
        chk(int'(stat0), 1, "R2 rise");
        chk(int'(pin0), 0, "R8 active low");
        field_in = 1'b0; step(3);
        chk(int'(stat0), 0, "R2 fall");
        // R3 / R9 communication start
        mode_cfg = 2'b01; step(2);
        start_in = 1'b1; step(3); start_in = 1'b0; step(5);
        chk(int'(stat0), 0, "R9 start without field");
        field_in = 1'b1; step(4);
        chk(int'(stat0), 0, "R3 field alone");
        start_in = 1'b1; step(3); start_in = 1'b0; step(3);
        chk(int'(stat0), 1, "R3 start seen");
        step(6);
        chk(int'(stat0), 1, "R3 held");
        field_in = 1'b0; step(5);
        chk(int'(stat0), 0, "R3 cleared on field loss");
        // R4 / R7 / R9 selection
        mode_cfg = 2'b10; step(2);
        sel = 1'b1; step(1); sel = 1'b0; step(3);
        chk(int'(stat0), 0, "R9 select without field");
        field_in = 1'b1; step(4);
        mode_cfg = 2'b00; step(4);
        chk(int'(stat0), 0, "R7 mode write ignored in session");
        sel = 1'b1; step(1); sel = 1'b0; step(1);
        chk(int'(stat0), 1, "R4 selected");
        step(4);
        chk(int'(stat0), 1, "R4 held");
        field_in = 1'b0; step(5);
        chk(int'(stat0), 0, "R4 cleared, R7 new mode follows field");
        // R5 / R6 pass-through
        mode_cfg = 2'b11; step(2);
        rdy = 1'b1; step(2);
        chk(int'(stat0), 1, "R5 ready rise");
        done = 1'b1; step(1); done = 1'b0; step(1);
        chk(int'(stat0), 0, "R6 toggle to 0");
        done = 1'b1; step(1); done = 1'b0; step(1);
        chk(int'(stat0), 1, "R6 toggle to 1");
        rdy = 1'b0; step(2);
        chk(int'(stat0), 1, "R5 ready fall keeps state");
        rdy = 1'b1; done = 1'b1; step(1); rdy = 1'b1; done = 1'b0; step(1);
        chk(int'(stat0), 0, "R6 done beats ready rise");
        rdy = 1'b0; step(1);
        rdy = 1'b1; step(2);
        chk(int'(stat0), 1, "R5 ready rise again");
        // R10 leaving pass-through
        mode_cfg = 2'b00; step(3);
        chk(int'(stat0), 0, "R10 left pass-through");
        mode_cfg = 2'b11; step(3);
        chk(int'(stat0), 0, "R10 cleared on return");
        // Mixed stimulus, judged by the every-cycle model comparison.
        for (int i = 0; i < 400; i++) begin
            if ($urandom_range(0, 19) == 0) field_in = ~field_in;
            if ($urandom_range(0, 9) == 0) start_in = ~start_in;
            sel  = ($urandom_range(0, 7) == 0);
            done = ($urandom_range(0, 5) == 0);
            if ($urandom_range(0, 3) == 0) rdy = ~rdy;
            if ($urandom_range(0, 15) == 0) mode_cfg = 2'($urandom_range(0, 3));
            step(1);
        end
        sel = 1'b0; done = 1'b0;
        step(2);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule